// File: doc/BRIEF.md
# Byte and Word Load/Store Alignment Unit

This block sits between a processor's execution stage and a byte-addressed data memory whose words are 32 bits wide. It takes a base register value, a signed 16-bit displacement, the store data, a small operation code and the word read back from memory. From these it forms the byte address, the word address sent to memory, the per-byte write strobes and the lane-aligned write data. On loads it also returns the register-ready result.

Word accesses must fall on a 4-byte boundary. When they do not, a flag is raised and every write strobe is held low. Byte accesses may use any address. A byte load takes the lane chosen by the two low address bits, using little-endian lane order. It then extends that byte to 32 bits, with sign extension or zero extension chosen by the operation code. A byte store copies the low byte of the store data onto every lane and enables only the addressed lane.

All paths are combinational. The widths of the address, the data word and the displacement are parameters, and the lane count is derived from the data width.

Top module: `lsa_align_unit`

## Requirements
- R1: The byte address is base_i plus offset_i sign-extended from 16 to 32 bits, taken modulo 2^32. word_addr_o equals that byte address divided by 4, which is its bits [31:2].
- R2: op_i is 3 bits wide: 0 = idle, 1 = word load, 2 = word store, 3 = signed byte load, 4 = unsigned byte load, 5 = byte store, and 6 and 7 act as idle. misalign_o is 1 exactly when op_i is 1 or 2 and the low two bits of the byte address are not 00.
- R3: For a word load, load_data_o equals mem_rdata_i.
- R4: For a signed byte load with lane k = byte address [1:0], load_data_o[7:0] equals mem_rdata_i[8k+7:8k], and bits 31..8 are copies of bit 7 of that byte.
- R5: For an unsigned byte load, load_data_o[7:0] equals the same lane byte as in R4, and bits 31..8 are zero.
- R6: For an aligned word store, wr_en_o is 4'b1111 and wr_data_o equals store_data_i.
- R7: For a byte store at any alignment, wr_data_o holds store_data_i[7:0] in all four lanes, and wr_en_o has only bit k set, where k = byte address [1:0].
- R8: For a misaligned word store, wr_en_o is 4'b0000.
- R9: For loads and idle codes, wr_en_o is 4'b0000. For any code other than 1, 3 and 4, load_data_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| base_i | input | 32 | Base register value |
| offset_i | input | 16 | Signed byte displacement |
| store_data_i | input | 32 | Register value to store |
| op_i | input | 3 | Operation code (see R2) |
| mem_rdata_i | input | 32 | Word read from memory |
| word_addr_o | output | 30 | Word index sent to memory |
| wr_en_o | output | 4 | Per-byte write strobes, bit k for bits 8k+7..8k |
| wr_data_o | output | 32 | Lane-placed write data |
| load_data_o | output | 32 | Extended load result |
| misalign_o | output | 1 | Word access not on a 4-byte boundary |

## Verification
The bench builds the unit with its default parameters: a 32-bit address, a 32-bit word and a 16-bit displacement, which gives four lanes. With these values it sweeps all eight operation codes against all four low-address residues. The displacements include zero, plus one, minus one and both 16-bit extremes, and the bases sit both mid-range and at the top of the address space. This reaches every lane, both extension modes, every misaligned word case and the wrap of the address add. The read words mix lanes with bit 7 set and clear, so sign extension and zero extension give different results.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

   typedef enum logic [2:0] {
      LSA_IDLE = 3'd0,
      LSA_LW   = 3'd1,
      LSA_SW   = 3'd2,
      LSA_LB   = 3'd3,
      LSA_LBU  = 3'd4,
      LSA_SB   = 3'd5
   } lsa_op_e;

   localparam int unsigned LSA_BYTE_W = 8;

   function automatic logic lsa_is_word(input logic [2:0] op);
      return (op == LSA_LW) || (op == LSA_SW);
   endfunction

   function automatic logic lsa_is_load(input logic [2:0] op);
      return (op == LSA_LW) || (op == LSA_LB) || (op == LSA_LBU);
   endfunction

endpackage

// File: rtl/lsa_addr_gen.sv
module lsa_addr_gen
   import lsa_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned OFF_W  = 16,
   parameter int unsigned SEL_W  = 2
) (
   input  logic [ADDR_W-1:0]       base_i,
   input  logic [OFF_W-1:0]        offset_i,
   input  logic [2:0]              op_i,
   output logic [ADDR_W-SEL_W-1:0] word_addr_o,
   output logic [SEL_W-1:0]        lane_o,
   output logic                    misalign_o
);

   logic [ADDR_W-1:0] off_ext;
   logic [ADDR_W-1:0] byte_addr;

   generate
      if (OFF_W > ADDR_W) begin : g_bad_off
         $error("lsa_addr_gen: OFF_W must not exceed ADDR_W");
      end else if (OFF_W == ADDR_W) begin : g_off_full
         assign off_ext = offset_i;
      end else begin : g_off_sext
         assign off_ext = {{(ADDR_W-OFF_W){offset_i[OFF_W-1]}}, offset_i};
      end
   endgenerate

   assign byte_addr   = base_i + off_ext;
   assign word_addr_o = byte_addr[ADDR_W-1:SEL_W];
   assign lane_o      = byte_addr[SEL_W-1:0];
   assign misalign_o  = lsa_is_word(op_i) && (lane_o != '0);

   always_comb begin
      if (misalign_o) begin
         AST_MISALIGN_WORD_ONLY: assert (lsa_is_word(op_i)); // R2
      end
      if (lsa_is_word(op_i) && (lane_o != '0)) begin
         AST_MISALIGN_RAISED: assert (misalign_o); // R2
      end
   end

endmodule

// File: rtl/lsa_store_lane.sv
module lsa_store_lane
   import lsa_pkg::*;
#(
   parameter int unsigned LANES = 4,
   parameter int unsigned SEL_W = 2
) (
   input  logic [2:0]                  op_i,
   input  logic [SEL_W-1:0]            lane_i,
   input  logic                        misalign_i,
   input  logic [LANES*LSA_BYTE_W-1:0] store_data_i,
   output logic [LANES-1:0]            wr_en_o,
   output logic [LANES*LSA_BYTE_W-1:0] wr_data_o
);

   logic word_st;
   logic byte_st;

   assign word_st = (op_i == LSA_SW) && !misalign_i;
   assign byte_st = (op_i == LSA_SB);

   generate
      for (genvar k = 0; k < LANES; k++) begin : g_lane
         assign wr_data_o[k*LSA_BYTE_W +: LSA_BYTE_W] =
            byte_st ? store_data_i[LSA_BYTE_W-1:0]
                    : store_data_i[k*LSA_BYTE_W +: LSA_BYTE_W];
         assign wr_en_o[k] = word_st ||
            (byte_st && (lane_i == SEL_W'(k)));
      end
   endgenerate

   always_comb begin
      if (op_i == LSA_SB) begin
         AST_BYTE_STORE_ONE_LANE: assert ($onehot(wr_en_o)); // R7
      end
      if (misalign_i) begin
         AST_NO_WRITE_MISALIGNED: assert (wr_en_o == '0); // R8
      end
      if ((op_i != LSA_SW) && (op_i != LSA_SB)) begin
         AST_NO_WRITE_OTHER_OPS: assert (wr_en_o == '0); // R9
      end
      if (word_st) begin
         AST_WORD_STORE_ALL_LANES: assert ($countones(wr_en_o) == LANES); // R6
      end
   end

endmodule

// File: rtl/lsa_load_extract.sv
module lsa_load_extract
   import lsa_pkg::*;
#(
   parameter int unsigned LANES = 4,
   parameter int unsigned SEL_W = 2
) (
   input  logic [2:0]                  op_i,
   input  logic [SEL_W-1:0]            lane_i,
   input  logic [LANES*LSA_BYTE_W-1:0] mem_rdata_i,
   output logic [LANES*LSA_BYTE_W-1:0] load_data_o
);

   localparam int unsigned WORD_W = LANES * LSA_BYTE_W;
   localparam int unsigned HIGH_W = WORD_W - LSA_BYTE_W;

   logic [LSA_BYTE_W-1:0] lane_byte [LANES];
   logic [LSA_BYTE_W-1:0] pick;

   generate
      for (genvar k = 0; k < LANES; k++) begin : g_split
         assign lane_byte[k] = mem_rdata_i[k*LSA_BYTE_W +: LSA_BYTE_W];
      end
   endgenerate

   assign pick = lane_byte[lane_i];

   always_comb begin
      case (op_i)
         LSA_LW:  load_data_o = mem_rdata_i;
         LSA_LB:  load_data_o = {{HIGH_W{pick[LSA_BYTE_W-1]}}, pick};
         LSA_LBU: load_data_o = {{HIGH_W{1'b0}}, pick};
         default: load_data_o = '0;
      endcase
   end

   always_comb begin
      if (op_i == LSA_LBU) begin
         AST_UNSIGNED_HIGH_ZERO: assert (load_data_o[WORD_W-1:LSA_BYTE_W] == '0); // R5
      end
      if (op_i == LSA_LB) begin
         AST_SIGNED_HIGH_COPY: assert (
            load_data_o[WORD_W-1:LSA_BYTE_W] == {HIGH_W{load_data_o[LSA_BYTE_W-1]}}); // R4
      end
      if (!lsa_is_load(op_i)) begin
         AST_NO_LOAD_RESULT: assert (load_data_o == '0); // R9
      end
   end

endmodule

// File: rtl/lsa_align_unit.sv
module lsa_align_unit
   import lsa_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned OFF_W  = 16,
   localparam int unsigned LANES  = DATA_W / LSA_BYTE_W,
   localparam int unsigned SEL_W  = $clog2(LANES),
   localparam int unsigned WADR_W = ADDR_W - SEL_W
) (
   input  logic [ADDR_W-1:0] base_i,
   input  logic [OFF_W-1:0]  offset_i,
   input  logic [DATA_W-1:0] store_data_i,
   input  logic [2:0]        op_i,
   input  logic [DATA_W-1:0] mem_rdata_i,
   output logic [WADR_W-1:0] word_addr_o,
   output logic [LANES-1:0]  wr_en_o,
   output logic [DATA_W-1:0] wr_data_o,
   output logic [DATA_W-1:0] load_data_o,
   output logic              misalign_o
);

   generate
      if ((DATA_W % LSA_BYTE_W) != 0) begin : g_bad_width
         $error("lsa_align_unit: DATA_W must be a multiple of 8");
      end
      if ((LANES < 2) || ((1 << SEL_W) != LANES)) begin : g_bad_lanes
         $error("lsa_align_unit: lane count must be a power of two, at least 2");
      end
      if (ADDR_W <= SEL_W) begin : g_bad_addr
         $error("lsa_align_unit: ADDR_W too small");
      end
   endgenerate

   logic [SEL_W-1:0] lane;

   lsa_addr_gen #(
      .ADDR_W (ADDR_W),
      .OFF_W  (OFF_W),
      .SEL_W  (SEL_W)
   ) i_addr_gen (
      .base_i      (base_i),
      .offset_i    (offset_i),
      .op_i        (op_i),
      .word_addr_o (word_addr_o),
      .lane_o      (lane),
      .misalign_o  (misalign_o)
   );

   lsa_store_lane #(
      .LANES (LANES),
      .SEL_W (SEL_W)
   ) i_store_lane (
      .op_i         (op_i),
      .lane_i       (lane),
      .misalign_i   (misalign_o),
      .store_data_i (store_data_i),
      .wr_en_o      (wr_en_o),
      .wr_data_o    (wr_data_o)
   );

   lsa_load_extract #(
      .LANES (LANES),
      .SEL_W (SEL_W)
   ) i_load_extract (
      .op_i        (op_i),
      .lane_i      (lane),
      .mem_rdata_i (mem_rdata_i),
      .load_data_o (load_data_o)
   );

endmodule

// File: tb/test_lsa_align_unit.sv
module test_lsa_align_unit;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] base;
   logic [15:0] offset;
   logic [31:0] sdata;
   logic [2:0]  op;
   logic [31:0] rdata;
   logic [29:0] word_addr;
   logic [3:0]  wr_en;
   logic [31:0] wr_data;
   logic [31:0] load_data;
   logic        misalign;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   lsa_align_unit i_lsa_align_unit (
      .base_i       (base),
      .offset_i     (offset),
      .store_data_i (sdata),
      .op_i         (op),
      .mem_rdata_i  (rdata),
      .word_addr_o  (word_addr),
      .wr_en_o      (wr_en),
      .wr_data_o    (wr_data),
      .load_data_o  (load_data),
      .misalign_o   (misalign)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s op=%0d base=%h off=%h got=%h exp=%h", tag, op, base, offset, got, exp);
      end
   endtask

   initial begin
      logic [31:0] offs  [5] = '{32'd0, 32'd1, 32'hFFFF_FFFF, 32'h0000_7FFF, 32'hFFFF_8000};
      logic [31:0] bases [2] = '{32'h1000_0000, 32'hFFFF_FFFC};
      logic [31:0] rds   [2] = '{32'h80FF_7F01, 32'h12F4_5A96};
      logic [31:0] sds   [2] = '{32'hA5C3_1E87, 32'h0F0F_0042};
      base = 32'h0; offset = 16'h0; sdata = 32'hDEAD_BEEF; op = 3'd0; rdata = 32'hFFFF_FFFF;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      @(negedge clk);
      // idle state after reset
      check("R9 idle wr_en", {28'h0, wr_en}, 32'h0);
      check("R9 idle load", load_data, 32'h0);
      check("R2 idle misalign", {31'h0, misalign}, 32'h0);
      for (int o = 0; o < 8; o++)
         for (int lo = 0; lo < 4; lo++)
            for (int fi = 0; fi < 5; fi++)
               for (int bi = 0; bi < 2; bi++)
                  for (int pi = 0; pi < 2; pi++) begin
                     logic [31:0] ea, bsel, exp_ld, exp_wd;
                     logic [3:0]  exp_we;
                     logic        word, mis;
                     int          ln;
                     @(posedge clk);
                     op     = 3'(o);
                     base   = bases[bi] + 32'(lo);
                     offset = offs[fi][15:0];
                     rdata  = rds[pi];
                     sdata  = sds[pi];
                     ea   = base + offs[fi];
                     ln   = int'(ea % 4);
                     bsel = (rdata >> (8 * ln)) & 32'hFF;
                     word = (o == 1) || (o == 2);
                     mis  = word && (ln != 0);
                     exp_we = (o == 2 && !mis) ? 4'hF : (o == 5) ? 4'(1 << ln) : 4'h0;
                     exp_wd = (o == 5) ? (sdata & 32'hFF) * 32'h0101_0101 : sdata;
                     if (o == 1)      exp_ld = rdata;
                     else if (o == 3) exp_ld = (bsel >= 128) ? bsel + 32'hFFFF_FF00 : bsel;
                     else if (o == 4) exp_ld = bsel;
                     else             exp_ld = 32'h0;
                     @(negedge clk);
                     check("R1 word address", {2'b00, word_addr}, ea / 4);
                     check("R2 misalign", {31'h0, misalign}, {31'h0, mis});
                     check(o == 5 ? "R7 byte strobes" : mis ? "R8 misaligned strobes" :
                           o == 2 ? "R6 word strobes" : "R9 no write", {28'h0, wr_en}, {28'h0, exp_we});
                     if (o == 2 || o == 5)
                        check(o == 5 ? "R7 byte data" : "R6 word data", wr_data, exp_wd);
                     check(o == 1 ? "R3 word load" : o == 3 ? "R4 signed byte" :
                           o == 4 ? "R5 unsigned byte" : "R9 no load", load_data, exp_ld);
                  end
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule